// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. It takes a virtual address on the miss port and uses the page-table root register to find a two-level page table in physical memory. It reads one entry per level over a valid/ready request channel with a separate response channel. These reads skip translation, because the tables live at physical addresses.

The top bits of the virtual address index the first-level table. The next bits index the second-level table that the first entry points to. The low bits are the page offset and the walker never uses them. An entry whose valid bit is clear ends the walk at once, at either level, and the walker reports a page fault for the missing page. If both entries are valid, the walker returns the physical page number and the permission bits of the leaf entry for the translation cache. Both results are one-cycle pulses tagged with the virtual page number. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. `miss_ready_o` is 1, and `mem_req_valid_o`, `refill_valid_o` and `fault_o` are all 0.
- R2: The first read goes to `root + 4*idx1`. Here idx1 is the top IDX_W bits of the virtual address, and root is the value of `root_i` in the cycle the miss is accepted. Later changes to `root_i` do not affect the walk in flight.
- R3: The second read goes to `(ppn1 << OFF_W) + 4*idx2`. Here ppn1 is bits PTE_BITS-1..OFF_W of the first-level entry, and idx2 is the IDX_W address bits just above the offset.
- R4: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and its address does not change.
- R5: The walker waits any number of cycles for the ready signal and for a response. A response that arrives while no read is outstanding has no effect on the state or the outputs.
- R6: A first-level entry with bit 0 (valid) clear ends the walk with a fault, and the second-level read is never issued.
- R7: A second-level entry with bit 0 clear ends the walk with a fault.
- R8: When both entries are valid, `refill_ppn_o` is leaf bits PTE_BITS-1..OFF_W. `refill_perm_o` bit k equals leaf bit k+1: bit 0 readable, bit 1 writable, bit 2 dirty, bit 3 user.
- R9: `refill_valid_o` and `fault_o` never rise together, each lasts exactly one cycle, and `refill_vpn_o` / `fault_vpn_o` carry the page number of the walked address.
- R10: A miss is accepted only while `miss_ready_o` is 1, which holds only when no walk is in progress. A miss presented during a walk is ignored.
- R11: With zero-wait memory, the result pulse appears 5 cycles after the accept edge for a refill or a second-level fault, and 3 cycles after it for a first-level fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request present |
| miss_ready_o | output | 1 | Walker idle, miss accepted |
| miss_vaddr_i | input | VA_W | Virtual address that missed |
| root_i | input | PTE_BITS | Physical base of the first-level table |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | PTE_BITS | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | PTE_BITS | Page-table entry read |
| refill_valid_o | output | 1 | One-cycle refill pulse |
| refill_vpn_o | output | 2*IDX_W | Page number being refilled |
| refill_ppn_o | output | PTE_BITS-OFF_W | Physical page number |
| refill_perm_o | output | 4 | {user, dirty, writable, readable} |
| fault_o | output | 1 | One-cycle page-fault pulse |
| fault_vpn_o | output | 2*IDX_W | Page number that faulted |

## Verification
The bench builds the walker with IDX_W=3, OFF_W=12 and PTE_BITS=32. The virtual page number then has only 6 bits, so every page is walked from each of three roots. The memory model is arithmetic: the content of each entry, including its valid bit, is a function of the entry's address. The sweep therefore reaches first-level faults, second-level faults and refills with no hand-written tables. The expected addresses and results are computed the same way. Four ready and response delay patterns rotate across the pages. In the same sweep, `root_i` changes after acceptance, competing misses arrive during walks, and one stray response is sent while the walker is idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_L1,
    ST_WAIT_L1,
    ST_REQ_L2,
    ST_WAIT_L2,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // entry bit positions
  localparam int unsigned BIT_VALID = 0;
  localparam int unsigned BIT_RD    = 1;
  localparam int unsigned BIT_WR    = 2;
  localparam int unsigned BIT_DIRTY = 3;
  localparam int unsigned BIT_USER  = 4;

  typedef struct packed {
    logic user;
    logic dirty;
    logic wr;
    logic rd;
  } perm_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_BITS = 32
) (
  input  logic [PTE_BITS-1:0]       root_i,
  input  logic [PTE_BITS-OFF_W-1:0] l1_ppn_i,
  input  logic [IDX_W-1:0]          idx1_i,
  input  logic [IDX_W-1:0]          idx2_i,
  input  logic                      sel_l2_i,
  output logic [PTE_BITS-1:0]       addr_o
);

  localparam int unsigned ENTRY_SHIFT = $clog2(PTE_BITS / 8);

  logic [PTE_BITS-1:0] base;
  logic [PTE_BITS-1:0] ofs;

  always_comb begin
    if (sel_l2_i) begin
      base = {l1_ppn_i, {OFF_W{1'b0}}};
      ofs  = PTE_BITS'(idx2_i) << ENTRY_SHIFT;
    end else begin
      base = root_i;
      ofs  = PTE_BITS'(idx1_i) << ENTRY_SHIFT;
    end
    addr_o = base + ofs;
  end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_BITS = 32
) (
  input  logic [PTE_BITS-1:0]       pte_i,
  output logic                      valid_o,
  output logic [PTE_BITS-OFF_W-1:0] ppn_o,
  output ptw_pkg::perm_t            perm_o
);

  import ptw_pkg::*;

  always_comb begin
    valid_o      = pte_i[BIT_VALID];
    ppn_o        = pte_i[PTE_BITS-1:OFF_W];
    perm_o.rd    = pte_i[BIT_RD];
    perm_o.wr    = pte_i[BIT_WR];
    perm_o.dirty = pte_i[BIT_DIRTY];
    perm_o.user  = pte_i[BIT_USER];
  end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 miss_valid_i,
  input  logic                 req_ready_i,
  input  logic                 rsp_valid_i,
  input  logic                 pte_valid_i,
  output ptw_pkg::walk_state_e state_o,
  output logic                 miss_ready_o,
  output logic                 req_valid_o,
  output logic                 sel_l2_o,
  output logic                 cap_miss_o,
  output logic                 cap_l1_o,
  output logic                 cap_l2_o,
  output logic                 refill_o,
  output logic                 fault_o
);

  import ptw_pkg::*;

  walk_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    cap_miss_o = 1'b0;
    cap_l1_o   = 1'b0;
    cap_l2_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (miss_valid_i) begin
        cap_miss_o = 1'b1;
        state_d    = ST_REQ_L1;
      end
      ST_REQ_L1: if (req_ready_i) state_d = ST_WAIT_L1;
      ST_WAIT_L1: if (rsp_valid_i) begin
        if (pte_valid_i) begin
          cap_l1_o = 1'b1;
          state_d  = ST_REQ_L2;
        end else begin
          state_d  = ST_FAULT;
        end
      end
      ST_REQ_L2: if (req_ready_i) state_d = ST_WAIT_L2;
      ST_WAIT_L2: if (rsp_valid_i) begin
        if (pte_valid_i) begin
          cap_l2_o = 1'b1;
          state_d  = ST_DONE;
        end else begin
          state_d  = ST_FAULT;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign state_o      = state_q;
  assign miss_ready_o = (state_q == ST_IDLE);
  assign req_valid_o  = (state_q == ST_REQ_L1) || (state_q == ST_REQ_L2);
  assign sel_l2_o     = (state_q == ST_REQ_L2);
  assign refill_o     = (state_q == ST_DONE);
  assign fault_o      = (state_q == ST_FAULT);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_BITS = 32,
  localparam int unsigned VPN_W   = 2 * IDX_W,
  localparam int unsigned VA_W    = VPN_W + OFF_W,
  localparam int unsigned PPN_W   = PTE_BITS - OFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                miss_valid_i,
  output logic                miss_ready_o,
  input  logic [VA_W-1:0]     miss_vaddr_i,
  input  logic [PTE_BITS-1:0] root_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [PTE_BITS-1:0] mem_req_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [PTE_BITS-1:0] mem_rsp_data_i,
  output logic                refill_valid_o,
  output logic [VPN_W-1:0]    refill_vpn_o,
  output logic [PPN_W-1:0]    refill_ppn_o,
  output logic [3:0]          refill_perm_o,
  output logic                fault_o,
  output logic [VPN_W-1:0]    fault_vpn_o
);

  import ptw_pkg::*;

  walk_state_e walk_state;
  logic sel_l2, cap_miss, cap_l1, cap_l2, pte_valid;
  logic [PPN_W-1:0] pte_ppn;
  perm_t pte_perm;

  logic [VPN_W-1:0]    vpn_q;
  logic [PTE_BITS-1:0] root_q;
  logic [PPN_W-1:0]    l1_ppn_q;
  logic [PPN_W-1:0]    leaf_ppn_q;
  perm_t               leaf_perm_q;

  ptw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .req_ready_i  (mem_req_ready_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .pte_valid_i  (pte_valid),
    .state_o      (walk_state),
    .miss_ready_o (miss_ready_o),
    .req_valid_o  (mem_req_valid_o),
    .sel_l2_o     (sel_l2),
    .cap_miss_o   (cap_miss),
    .cap_l1_o     (cap_l1),
    .cap_l2_o     (cap_l2),
    .refill_o     (refill_valid_o),
    .fault_o      (fault_o)
  );

  ptw_pte_decode #(.OFF_W(OFF_W), .PTE_BITS(PTE_BITS)) u_dec (
    .pte_i   (mem_rsp_data_i),
    .valid_o (pte_valid),
    .ppn_o   (pte_ppn),
    .perm_o  (pte_perm)
  );

  ptw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_BITS(PTE_BITS)) u_addr (
    .root_i   (root_q),
    .l1_ppn_i (l1_ppn_q),
    .idx1_i   (vpn_q[VPN_W-1:IDX_W]),
    .idx2_i   (vpn_q[IDX_W-1:0]),
    .sel_l2_i (sel_l2),
    .addr_o   (mem_req_addr_o)
  );

  // root sampled with the miss so a mid-walk write cannot split a walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      root_q <= '0;
    end else if (cap_miss) begin
      vpn_q  <= miss_vaddr_i[VA_W-1:OFF_W];
      root_q <= root_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_ppn_q    <= '0;
      leaf_ppn_q  <= '0;
      leaf_perm_q <= '0;
    end else begin
      if (cap_l1) l1_ppn_q <= pte_ppn;
      if (cap_l2) begin
        leaf_ppn_q  <= pte_ppn;
        leaf_perm_q <= pte_perm;
      end
    end
  end

  assign refill_vpn_o  = vpn_q;
  assign fault_vpn_o   = vpn_q;
  assign refill_ppn_o  = leaf_ppn_q;
  assign refill_perm_o = leaf_perm_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_BITS = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         miss_valid_i,
  input logic                         miss_ready_o,
  input logic                         mem_req_valid_o,
  input logic                         mem_req_ready_i,
  input logic [PTE_BITS-1:0]          mem_req_addr_o,
  input logic                         mem_rsp_valid_i,
  input logic [PTE_BITS-1:0]          mem_rsp_data_i,
  input logic                         refill_valid_o,
  input logic [PTE_BITS-OFF_W-1:0]    refill_ppn_o,
  input logic                         fault_o,
  input ptw_pkg::walk_state_e         state
);

  import ptw_pkg::*;

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r5_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o && !miss_valid_i |=> miss_ready_o && !refill_valid_o && !fault_o);

  a_r6_l1_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_WAIT_L1 && mem_rsp_valid_i && !mem_rsp_data_i[BIT_VALID] |=> fault_o);

  a_r7_l2_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_WAIT_L2 && mem_rsp_valid_i && !mem_rsp_data_i[BIT_VALID] |=> fault_o);

  a_r8_refill_ppn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_WAIT_L2 && mem_rsp_valid_i && mem_rsp_data_i[BIT_VALID]
    |=> refill_valid_o && refill_ppn_o == $past(mem_rsp_data_i[PTE_BITS-1:OFF_W]));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refill_valid_o && fault_o));

  a_r9_refill_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_o |=> !refill_valid_o);

  a_r9_fault_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  a_r10_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o && miss_valid_i |=> !miss_ready_o && mem_req_valid_o);

  a_r10_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_o || fault_o |=> miss_ready_o);

endmodule

bind ptw_walker ptw_walker_chk #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_BITS(PTE_BITS)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_data_i  (mem_rsp_data_i),
  .refill_valid_o  (refill_valid_o),
  .refill_ppn_o    (refill_ppn_o),
  .fault_o         (fault_o),
  .state           (walk_state)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

  localparam int unsigned IDX_W = 3;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PB    = 32;
  localparam int unsigned VPN_W = 2 * IDX_W;
  localparam int unsigned VA_W  = VPN_W + OFF_W;
  localparam int unsigned PPN_W = PB - OFF_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic miss_valid_i = 1'b0;
  logic miss_ready_o;
  logic [VA_W-1:0] miss_vaddr_i = '0;
  logic [PB-1:0] root_i = '0;
  logic mem_req_valid_o;
  logic mem_req_ready_i = 1'b0;
  logic [PB-1:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [PB-1:0] mem_rsp_data_i = '0;
  logic refill_valid_o;
  logic [VPN_W-1:0] refill_vpn_o;
  logic [PPN_W-1:0] refill_ppn_o;
  logic [3:0] refill_perm_o;
  logic fault_o;
  logic [VPN_W-1:0] fault_vpn_o;

  always #10 clk_i = ~clk_i;

  ptw_walker #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_BITS(PB)) dut (.*);

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // arithmetic page-table contents: entry is a function of its address
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] w, m, p;
    w = a >> 2;
    m = w * 13 + 32'h100;
    p = w * 3;
    return {m[19:0], 7'b0, p[3:0], ((w % 5) != 0)};
  endfunction

  // memory responder
  int rdy_delay = 0, rsp_lat = 0, rdy_cnt = 0, rsp_cnt = 0;
  bit rsp_pend = 0, req_seen = 0, inject = 0;
  logic [31:0] rsp_addr = '0, first_addr = '0;
  int stab_err = 0, n_req = 0;
  logic [31:0] addr_log [4];

  initial forever begin
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    if (inject) begin
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i  = 32'hFFFF_F01F;
      inject = 0;
    end else if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = pte_of(rsp_addr);
        rsp_pend = 0;
      end else rsp_cnt--;
    end
    mem_req_ready_i = 1'b0;
    if (mem_req_valid_o && !rsp_pend && !mem_rsp_valid_i) begin
      if (!req_seen) begin
        req_seen = 1; first_addr = mem_req_addr_o; rdy_cnt = rdy_delay;
      end else if (mem_req_addr_o != first_addr) stab_err++;
      if (rdy_cnt == 0) begin
        mem_req_ready_i = 1'b1;
        rsp_addr = mem_req_addr_o;
        rsp_pend = 1; rsp_cnt = rsp_lat; req_seen = 0;
        if (n_req < 4) addr_log[n_req] = mem_req_addr_o;
        n_req++;
      end else rdy_cnt--;
    end
  end

  task automatic walk(input logic [31:0] root, input logic [VPN_W-1:0] vpn,
                      input logic [OFF_W-1:0] off, input int pat, input bit intrude);
    logic [31:0] l1a, l2a, p1, p2;
    logic exp_fault;
    int exp_n, exp_cyc, cyc;
    l1a = root + 32'(vpn[VPN_W-1:IDX_W]) * 4;
    p1 = pte_of(l1a);
    l2a = {p1[31:12], 12'b0} + 32'(vpn[IDX_W-1:0]) * 4;
    p2 = pte_of(l2a);
    if (!p1[0]) begin exp_fault = 1; exp_n = 1; exp_cyc = 3; end
    else if (!p2[0]) begin exp_fault = 1; exp_n = 2; exp_cyc = 5; end
    else begin exp_fault = 0; exp_n = 2; exp_cyc = 5; end

    @(negedge clk_i);
    case (pat)
      0: begin rdy_delay = 0; rsp_lat = 0; end
      1: begin rdy_delay = 2; rsp_lat = 3; end
      2: begin rdy_delay = 1; rsp_lat = 0; end
      default: begin rdy_delay = 0; rsp_lat = 5; end
    endcase
    n_req = 0; stab_err = 0;
    root_i = root;
    miss_valid_i = 1'b1;
    miss_vaddr_i = {vpn, off};
    chk("R10 ready before accept", 32'(miss_ready_o), 1);
    @(negedge clk_i);
    miss_valid_i = 1'b0;
    root_i = ~root; // R2: must not affect this walk
    chk("R10 busy after accept", 32'(miss_ready_o), 0);
    cyc = 1;
    while (!(refill_valid_o || fault_o) && cyc < 200) begin
      if (intrude && cyc == 2) begin
        miss_valid_i = 1'b1;
        miss_vaddr_i = ~{vpn, off};
      end
      @(negedge clk_i);
      cyc++;
    end
    miss_valid_i = 1'b0;
    if (cyc >= 200) chk("R5 walk timeout", 32'(cyc), 32'(exp_cyc));
    if (exp_fault) begin
      chk("R6/R7 fault", 32'(fault_o), 1);
      chk("R9 fault vpn", 32'(fault_vpn_o), 32'(vpn));
      chk("R9 no refill", 32'(refill_valid_o), 0);
    end else begin
      chk("R8 refill", 32'(refill_valid_o), 1);
      chk("R9 refill vpn", 32'(refill_vpn_o), 32'(vpn));
      chk("R8 ppn", 32'(refill_ppn_o), 32'(p2[31:12]));
      chk("R8 perm", 32'(refill_perm_o), 32'(p2[4:1]));
      chk("R9 no fault", 32'(fault_o), 0);
    end
    chk(exp_n == 1 ? "R6 no L2 read" : "R3 read count", 32'(n_req), 32'(exp_n));
    chk("R2 L1 addr", addr_log[0], l1a);
    if (exp_n == 2) chk("R3 L2 addr", addr_log[1], l2a);
    chk("R4 addr stable", 32'(stab_err), 0);
    if (pat == 0) chk("R11 latency", 32'(cyc), 32'(exp_cyc));
    @(negedge clk_i);
    chk("R9 pulse width", 32'({refill_valid_o, fault_o}), 0);
    chk("R10 idle again", 32'(miss_ready_o), 1);
    root_i = root;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] roots [3];
    roots[0] = 32'h0004_0000;
    roots[1] = 32'h0000_0000;
    roots[2] = 32'h0123_4568;
    repeat (3) @(negedge clk_i);
    chk("R1 ready in reset", 32'(miss_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", 32'(miss_ready_o), 1);
    chk("R1 no req", 32'(mem_req_valid_o), 0);
    chk("R1 no pulses", 32'({refill_valid_o, fault_o}), 0);

    for (int r = 0; r < 3; r++)
      for (int v = 0; v < (1 << VPN_W); v++)
        walk(roots[r], VPN_W'(v), OFF_W'(v * 37), v % 4, (v % 3) == 1);

    // R5: stray response while idle
    @(negedge clk_i);
    inject = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R5 stray rsp idle", 32'({miss_ready_o, mem_req_valid_o, refill_valid_o, fault_o}), 32'b1000);
    end
    walk(roots[0], 6'd5, 12'h123, 0, 0);
    summary();
  end

endmodule